// File: doc/BRIEF.md
# Row Scan Sequencer with Vertical Mirror and Per-Edge Driver Flip

This block sequences the multiplexed row scan of a 65-row display. A frame has 65 scan slots: 64 graphic rows and one icon row. In every slot the block says which display-memory row the column path must read, and which row driver must receive that data, as a one-hot select. A slot advances on each pulse of a scan-clock enable. After the last slot the counter wraps and a one-cycle frame-start flag is raised.

Three configuration bits change the picture without touching memory contents. A vertical mirror bit reverses the order in which the graphic rows are read (row 63 first instead of row 0), which mirrors the image about the horizontal axis. Drivers take data purely in read order. Two flip bits reverse the order of the driver pads inside each 32-row sub-block: one bit for the sub-block on the interface edge of the die (drivers 0..31) and one for the sub-block on the far edge (drivers 32..63). The icon row is always read last and always goes to driver 64. The configuration is captured only when a frame begins, so a frame is never shown half mirrored.

Top module: `rowscan_seq`

## Requirements
- R1: While reset is high and after it is released, until the first enable, the slot is 0, mem_row is 0, drv_sel has only bit 0 set, frame_start is 0, and the active configuration is all zero (no mirror, no flip).
- R2: Each clock with scan_en high advances the slot by one; with scan_en low the slot holds. The outputs for the new slot appear in the cycle after the enabling edge.
- R3: An enable in slot 64 wraps the slot to 0, and frame_start is high for exactly that one cycle following the wrap; it is low at every other time.
- R4: For graphic slots 0..63, mem_row equals the slot when the active mirror bit is 0, and 63 minus the slot when it is 1.
- R5: In slot 64 mem_row is 64 (icon row) and drv_sel has only bit 64 set, whatever the configuration.
- R6: drv_sel always has exactly one bit set; bit i selects row driver i. With both flip bits 0, the driver index equals the slot.
- R7: With the interface-edge flip bit at 1, slots 0..31 drive driver 31 minus the slot; slots 32..63 are not affected by this bit.
- R8: With the far-edge flip bit at 1, slots 32..63 drive driver 95 minus the slot; slots 0..31 are not affected by this bit.
- R9: The configuration inputs are captured only by the enable that wraps slot 64 to 0; a change at any other time has no effect on mem_row or drv_sel until that wrap.
- R10: The driver index depends only on the slot and the flip bits, never on the mirror bit; mem_row depends only on the slot and the mirror bit, never on the flip bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| scan_en | input | 1 | Scan-clock enable; one slot advance per high cycle |
| cfg_mirror_y | input | 1 | Vertical mirror request (read rows 63 down to 0) |
| cfg_flip_near | input | 1 | Reverse driver order in the interface-edge sub-block |
| cfg_flip_far | input | 1 | Reverse driver order in the far-edge sub-block |
| frame_start | output | 1 | One-cycle flag in the first cycle of slot 0 after a wrap |
| slot_idx | output | 7 | Current scan slot, 0..64 |
| mem_row | output | 7 | Display-memory row to read, 64 for the icon row |
| drv_sel | output | 65 | One-hot row driver select |

## Verification
All outputs come from registers with no further pipeline stage, so slot_idx, mem_row, drv_sel and frame_start take their new values in the cycle right after the clock edge that sampled scan_en high, and a configuration change shows first in slot 0 of the next frame, one cycle after the wrapping edge. The bench drives inputs and reads outputs on the falling edge, while its reference model steps on the rising edge from the same sampled inputs, so every compare lands half a cycle after the edge that made the value. Configuration changes are driven in the middle of frames and again just before a wrap, with enable patterns that include gaps, to show the one-frame latency and the hold behaviour.

// File: rtl/rowscan_pkg.sv
package rowscan_pkg;

    // Default geometry: graphic rows, split evenly over two die edges.
    localparam int DEF_GFX_ROWS = 64;

    // Active scan configuration, captured once per frame.
    typedef struct packed {
        logic mirror;     // read graphic rows in reverse order
        logic flip_near;  // reverse drivers on the interface edge
        logic flip_far;   // reverse drivers on the far edge
    } scan_cfg_t;

    localparam scan_cfg_t CFG_IDLE = '{mirror: 1'b0, flip_near: 1'b0, flip_far: 1'b0};

    // Position of an element after reversing a run of 'size' entries.
    function automatic int rev_pos(input int pos, input int size);
        return size - 1 - pos;
    endfunction

    // Sub-block number of a graphic row (0 = interface edge, 1 = far edge).
    function automatic int edge_of(input int row, input int half);
        return row / half;
    endfunction

endpackage

// File: rtl/rs_slot_ctr.sv
module rs_slot_ctr #(
    parameter int SLOTS = 65,
    parameter int SW    = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [SW-1:0] slot,
    output logic          wrap_now,
    output logic          frame_q
);
    localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);

    assign wrap_now = adv && (slot == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot    <= '0;
            frame_q <= 1'b0;
        end else begin
            frame_q <= wrap_now;
            if (wrap_now) begin
                slot <= '0;
            end else if (adv) begin
                slot <= slot + SW'(1);
            end
        end
    end
endmodule

// File: rtl/rs_cfg_hold.sv
module rs_cfg_hold
    import rowscan_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  scan_cfg_t cfg_in,
    output scan_cfg_t cfg_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_IDLE;
        end else if (load) begin
            cfg_q <= cfg_in;
        end
    end
endmodule

// File: rtl/rs_row_map.sv
module rs_row_map #(
    parameter int GFX_ROWS = 64,
    parameter int SW       = $clog2(GFX_ROWS + 1)
) (
    input  logic [SW-1:0] slot,
    input  logic          mirror,
    output logic [SW-1:0] mem_row
);
    localparam logic [SW-1:0] ICON_ROW = SW'(GFX_ROWS);
    localparam logic [SW-1:0] TOP_ROW  = SW'(GFX_ROWS - 1);

    always_comb begin
        if (slot >= ICON_ROW) begin
            mem_row = ICON_ROW;
        end else if (mirror) begin
            mem_row = TOP_ROW - slot;
        end else begin
            mem_row = slot;
        end
    end
endmodule

// File: rtl/rs_drv_map.sv
module rs_drv_map
    import rowscan_pkg::*;
#(
    parameter int GFX_ROWS = 64,
    parameter int SW       = $clog2(GFX_ROWS + 1)
) (
    input  logic [SW-1:0]     slot,
    input  logic              flip_near,
    input  logic              flip_far,
    output logic [GFX_ROWS:0] drv_sel
);
    localparam int HALF = GFX_ROWS / 2;

    for (genvar d = 0; d < GFX_ROWS; d++) begin : g_drv
        localparam int BLK  = edge_of(d, HALF);
        localparam int POS  = d % HALF;
        localparam int SRC_STRAIGHT = d;
        localparam int SRC_REVERSED = BLK * HALF + rev_pos(POS, HALF);
        logic flip;
        if (BLK == 0) begin : g_near
            assign flip = flip_near;
        end else begin : g_far
            assign flip = flip_far;
        end
        assign drv_sel[d] = flip ? (slot == SW'(SRC_REVERSED))
                                 : (slot == SW'(SRC_STRAIGHT));
    end

    assign drv_sel[GFX_ROWS] = (slot == SW'(GFX_ROWS));
endmodule

// File: rtl/rowscan_seq.sv
module rowscan_seq
    import rowscan_pkg::*;
#(
    parameter int GFX_ROWS = DEF_GFX_ROWS,
    localparam int SLOTS   = GFX_ROWS + 1,
    localparam int SW      = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scan_en,
    input  logic              cfg_mirror_y,
    input  logic              cfg_flip_near,
    input  logic              cfg_flip_far,
    output logic              frame_start,
    output logic [SW-1:0]     slot_idx,
    output logic [SW-1:0]     mem_row,
    output logic [GFX_ROWS:0] drv_sel
);
    scan_cfg_t cfg_req;
    scan_cfg_t cfg_q;
    logic      wrap_now;

    assign cfg_req = '{mirror: cfg_mirror_y, flip_near: cfg_flip_near, flip_far: cfg_flip_far};

    rs_slot_ctr #(.SLOTS(SLOTS), .SW(SW)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .adv      (scan_en),
        .slot     (slot_idx),
        .wrap_now (wrap_now),
        .frame_q  (frame_start)
    );

    rs_cfg_hold u_cfg (
        .clk    (clk),
        .rst    (rst),
        .load   (wrap_now),
        .cfg_in (cfg_req),
        .cfg_q  (cfg_q)
    );

    rs_row_map #(.GFX_ROWS(GFX_ROWS), .SW(SW)) u_row (
        .slot    (slot_idx),
        .mirror  (cfg_q.mirror),
        .mem_row (mem_row)
    );

    rs_drv_map #(.GFX_ROWS(GFX_ROWS), .SW(SW)) u_drv (
        .slot      (slot_idx),
        .flip_near (cfg_q.flip_near),
        .flip_far  (cfg_q.flip_far),
        .drv_sel   (drv_sel)
    );
endmodule

// File: rtl/rowscan_seq_chk.sv
module rowscan_seq_chk #(
    parameter int GFX_ROWS = 64,
    localparam int SW      = $clog2(GFX_ROWS + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              scan_en,
    input logic              cfg_mirror_y,
    input logic              cfg_flip_near,
    input logic              cfg_flip_far,
    input logic              frame_start,
    input logic [SW-1:0]     slot_idx,
    input logic [SW-1:0]     mem_row,
    input logic [GFX_ROWS:0] drv_sel,
    input logic [2:0]        cfg_act
);
    localparam logic [SW-1:0] LAST = SW'(GFX_ROWS);

    // R2: slot never leaves its range
    a_r2_slot_range: assert property (@(posedge clk) disable iff (rst)
        slot_idx <= LAST);

    // R2: one step per enable below the last slot
    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        (scan_en && slot_idx != LAST) |=> slot_idx == SW'($past(slot_idx) + SW'(1)));

    // R2: hold without enable
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !scan_en |=> $stable(slot_idx));

    // R3: wrap raises frame_start in slot 0
    a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
        (scan_en && slot_idx == LAST) |=> (frame_start && slot_idx == '0));

    // R3: frame_start lasts one cycle
    a_r3_one_cycle: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !frame_start);

    // R5: icon slot reads icon row and drives last driver
    a_r5_icon: assert property (@(posedge clk) disable iff (rst)
        (slot_idx == LAST) |-> (mem_row == LAST && drv_sel[GFX_ROWS]));

    // R6: exactly one driver selected
    a_r6_onehot: assert property (@(posedge clk) disable iff (rst)
        $countones(drv_sel) == 1);

    // R9: active configuration changes only at a frame start
    a_r9_cfg_frame_only: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg_act) |-> frame_start);

    // R9: captured value is the request present at the wrapping edge
    a_r9_cfg_capture: assert property (@(posedge clk) disable iff (rst)
        (scan_en && slot_idx == LAST) |=>
            cfg_act == $past({cfg_mirror_y, cfg_flip_near, cfg_flip_far}));

    // R4: graphic rows stay in the graphic range
    a_r4_gfx_range: assert property (@(posedge clk) disable iff (rst)
        (slot_idx != LAST) |-> mem_row < LAST);
endmodule

bind rowscan_seq rowscan_seq_chk #(.GFX_ROWS(GFX_ROWS)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .scan_en       (scan_en),
    .cfg_mirror_y  (cfg_mirror_y),
    .cfg_flip_near (cfg_flip_near),
    .cfg_flip_far  (cfg_flip_far),
    .frame_start   (frame_start),
    .slot_idx      (slot_idx),
    .mem_row       (mem_row),
    .drv_sel       (drv_sel),
    .cfg_act       (cfg_q)
);

// File: tb/rowscan_seq_tb.sv
module rowscan_seq_tb;
    localparam int ROWS  = 64;
    localparam int SLOTS = ROWS + 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scan_en = 1'b0;
    logic        cfg_mirror_y = 1'b0;
    logic        cfg_flip_near = 1'b0;
    logic        cfg_flip_far = 1'b0;
    logic        frame_start;
    logic [6:0]  slot_idx;
    logic [6:0]  mem_row;
    logic [64:0] drv_sel;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // reference model state
    int m_slot = 0;
    int m_fs   = 0;
    int m_mir  = 0;
    int m_fn   = 0;
    int m_ff   = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    rowscan_seq u_dut (
        .clk           (clk),
        .rst           (rst),
        .scan_en       (scan_en),
        .cfg_mirror_y  (cfg_mirror_y),
        .cfg_flip_near (cfg_flip_near),
        .cfg_flip_far  (cfg_flip_far),
        .frame_start   (frame_start),
        .slot_idx      (slot_idx),
        .mem_row       (mem_row),
        .drv_sel       (drv_sel)
    );

    function automatic int exp_row(int s, int mir);
        if (s == ROWS) return ROWS;
        return mir ? (ROWS - 1 - s) : s;
    endfunction

    function automatic int exp_drv(int s, int fn, int ff);
        int blk;
        int pos;
        int fl;
        if (s == ROWS) return ROWS;
        blk = s / 32;
        pos = s % 32;
        fl  = (blk == 0) ? fn : ff;
        return blk * 32 + (fl ? (31 - pos) : pos);
    endfunction

    function automatic int onehot_idx(logic [64:0] v);
        int idx = -1;
        int cnt = 0;
        for (int i = 0; i < SLOTS; i++) begin
            if (v[i]) begin
                idx = i;
                cnt++;
            end
        end
        return (cnt == 1) ? idx : -1;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (slot %0d, t=%0t)", tag, act, exp, m_slot, $time);
        end
    endtask

    // reference model steps on the rising edge from the sampled inputs
    always @(posedge clk) begin
        if (rst) begin
            m_slot = 0; m_fs = 0; m_mir = 0; m_fn = 0; m_ff = 0;
        end else if (scan_en) begin
            if (m_slot == ROWS) begin
                m_slot = 0; m_fs = 1;
                m_mir = cfg_mirror_y; m_fn = cfg_flip_near; m_ff = cfg_flip_far;
            end else begin
                m_slot = m_slot + 1; m_fs = 0;
            end
        end else begin
            m_fs = 0;
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        int ed;
        int ad;
        cycles++;
        if (!rst && !done) begin
            chk(int'(slot_idx) == m_slot, "R2 slot", int'(slot_idx), m_slot);
            chk(int'(frame_start) == m_fs, "R3 frame_start", int'(frame_start), m_fs);
            chk(int'(mem_row) == exp_row(m_slot, m_mir),
                (m_slot == ROWS) ? "R5 icon mem_row" : "R4 mem_row",
                int'(mem_row), exp_row(m_slot, m_mir));
            ed = exp_drv(m_slot, m_fn, m_ff);
            ad = onehot_idx(drv_sel);
            chk(ad == ed,
                (m_slot == ROWS) ? "R5 icon driver" :
                (m_slot < 32 && m_fn != 0) ? "R7 near flip driver" :
                (m_slot >= 32 && m_ff != 0) ? "R8 far flip driver" : "R6 driver",
                ad, ed);
        end
    end

    initial begin
        while (cycles < 200000) @(negedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic steps(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            scan_en = (gap == 0) ? 1'b1 : ((i % gap) != 0);
        end
    endtask

    task automatic set_cfg(input bit m, input bit fn, input bit ff);
        cfg_mirror_y = m; cfg_flip_near = fn; cfg_flip_far = ff;
    endtask

    // advance until the model shows slot s, then stop enabling
    task automatic go_to(input int s);
        @(negedge clk);
        scan_en = 1'b1;
        while (m_slot != ((s + SLOTS - 1) % SLOTS)) @(negedge clk);
        @(negedge clk);
        scan_en = 1'b0;
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(slot_idx == 7'd0, "R1 reset slot", int'(slot_idx), 0);
        chk(mem_row == 7'd0, "R1 reset mem_row", int'(mem_row), 0);
        chk(onehot_idx(drv_sel) == 0, "R1 reset driver", onehot_idx(drv_sel), 0);
        chk(frame_start == 1'b0, "R1 reset frame_start", int'(frame_start), 0);
        rst = 1'b0;
        // R1: config requested before first wrap is not yet active
        set_cfg(1'b1, 1'b1, 1'b1);
        @(negedge clk);
        chk(mem_row == 7'd0, "R1 idle config mem_row", int'(mem_row), 0);
        chk(onehot_idx(drv_sel) == 0, "R1 idle config driver", onehot_idx(drv_sel), 0);
        set_cfg(1'b0, 1'b0, 1'b0);

        // first frame with gaps, then all eight configurations
        steps(2 * SLOTS, 3);
        for (int c = 0; c < 8; c++) begin
            set_cfg(c[2], c[1], c[0]);
            steps(SLOTS + 10, (c % 2 == 0) ? 0 : 4);
        end

        // R9: mirror request mid-frame is held off until the wrap
        set_cfg(1'b0, 1'b0, 1'b0);
        go_to(0);
        go_to(0);
        go_to(10);
        set_cfg(1'b1, 1'b1, 1'b0);
        @(negedge clk);
        scan_en = 1'b1;
        @(negedge clk);
        scan_en = 1'b0;
        chk(mem_row == 7'd11, "R9 mid-frame mirror ignored", int'(mem_row), 11);
        chk(onehot_idx(drv_sel) == 11, "R9 mid-frame flip ignored", onehot_idx(drv_sel), 11);
        go_to(0);
        chk(mem_row == 7'd63, "R9 mirror active after wrap", int'(mem_row), 63);
        chk(onehot_idx(drv_sel) == 31, "R7 near flip slot 0", onehot_idx(drv_sel), 31);

        // R10: mirror alone leaves drivers straight, flips alone leave rows straight
        set_cfg(1'b1, 1'b0, 1'b0);
        go_to(0);
        go_to(40);
        chk(onehot_idx(drv_sel) == 40, "R10 mirror keeps driver", onehot_idx(drv_sel), 40);
        chk(mem_row == 7'd23, "R10 mirror row", int'(mem_row), 23);
        set_cfg(1'b0, 1'b1, 1'b1);
        go_to(0);
        go_to(40);
        chk(mem_row == 7'd40, "R10 flips keep row", int'(mem_row), 40);
        chk(onehot_idx(drv_sel) == 55, "R8 far flip slot 40", onehot_idx(drv_sel), 55);
        go_to(64);
        chk(mem_row == 7'd64 && drv_sel[64], "R5 icon under flips", int'(mem_row), 64);

        // R3: frame_start exactly on wrap, gone next cycle
        @(negedge clk);
        scan_en = 1'b1;
        @(negedge clk);
        scan_en = 1'b0;
        chk(frame_start == 1'b1 && slot_idx == 7'd0, "R3 wrap flag", int'(frame_start), 1);
        @(negedge clk);
        chk(frame_start == 1'b0, "R3 flag one cycle", int'(frame_start), 0);

        steps(3 * SLOTS, 2);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule